// File: doc/BRIEF.md
# Channel-Tagged Sample Buffer

This block is a first-in first-out store for converted samples coming from up to thirty-two input channels. Each sample arrives with the number of the channel that produced it. The block packs the two into one 32-bit word. The channel number travels inside the word because samples from different channels can reach the buffer in any order. A host bus pops words from the read side one at a time.

The sample field can be 16, 18, 20 or 24 bits wide. Any bits between the top of the sample field and the tag are forced to zero. The block also provides:
- an occupancy count;
- a fill-level flag set against a programmable threshold, which can be copied to an auxiliary output;
- sticky flags for writes attempted on a full buffer and for reads attempted on an empty one.

Host controls can flush the buffer with a single-cycle clear pulse, or stop new samples from entering while the stored words are still read out.

Top module: `tagged_sample_fifo`

## Requirements
- R1: Every stored word has bits 31..29 at zero, the 5-bit channel tag in bits 28..24 and the sample in the low bits.
- R2: `width_sel` picks the sample width at write time: 0 gives 16 bits, 1 gives 18, 2 gives 20 and 3 gives 24. Sample bits above the chosen width, up to bit 23, are stored as zero.
- R3: Words leave in the order they entered. Each accepted write adds one to `level` and each accepted read takes one away.
- R4: A write while `level` equals DEPTH is dropped, leaving the stored words unchanged, and sets `ovf_flag`.
- R5: A read while the buffer is empty returns zero on `rd_data` and sets `underflow_flag`.
- R6: `ovf_flag` and `underflow_flag` stay at 1 until a `flag_wr` cycle writes 0 to them, or until reset. Writing 1 through `flag_wr` has no effect. If an event and a clearing write fall in the same cycle, the event wins.
- R7: `thresh_flag` is 1 exactly when `level` is strictly greater than `thresh`. `aux_out` copies `thresh_flag` when `aux_sel` is 1 and is 0 otherwise.
- R8: A `clr` pulse empties the buffer: `level` is 0 after that edge. Reads and writes presented in the same cycle are ignored. The sticky flags are not changed by a clear.
- R9: While `wr_enable` is 0, incoming samples are ignored and do not set `ovf_flag`. Stored words can still be read.
- R10: After reset, `level` is 0, `empty` is 1, `rd_data` is 0 and both sticky flags are 0.
- R11: A read and a write in the same cycle, with the buffer neither empty nor full, leave `level` unchanged and return the oldest word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | A sample is offered this cycle |
| wr_tag | input | 5 | Channel number of the sample |
| wr_sample | input | 24 | Sample value, right-aligned |
| width_sel | input | 2 | Sample width code (see R2) |
| wr_enable | input | 1 | 1 lets samples into the buffer |
| clr | input | 1 | Single-cycle buffer flush |
| rd_req | input | 1 | Pop one word |
| rd_data | output | 32 | Popped word, valid the cycle after `rd_req` |
| level | output | $clog2(DEPTH+1) | Number of stored words |
| full | output | 1 | `level` equals DEPTH |
| empty | output | 1 | `level` is zero |
| thresh | input | $clog2(DEPTH+1) | Fill threshold |
| thresh_flag | output | 1 | `level` > `thresh` |
| aux_sel | input | 1 | Route `thresh_flag` to `aux_out` |
| aux_out | output | 1 | Auxiliary copy of the threshold flag |
| flag_wr | input | 1 | Host write strobe for the sticky flags |
| flag_wdata | input | 2 | Bit 0 for overflow, bit 1 for underflow; a 0 clears |
| ovf_flag | output | 1 | Sticky overflow |
| underflow_flag | output | 1 | Sticky underflow |

## Verification
The assertions assume that `width_sel` holds a known value in every write cycle and that `clr` lasts only one cycle. They also assume that no input is X once reset has been released. The stimulus changes every input only on the falling edge, so each one is stable across the rising edge. It pulses `clr` for exactly one cycle and always drives all inputs to defined values. The directed part deliberately overruns and underruns the buffer, then clears the sticky flags, so the event-versus-clear ordering is exercised under these assumptions.

// File: rtl/tsf_pkg.sv
// Package: shared types for the tagged sample buffer.
// Assumes: width code values are fixed by the host control field.
package tsf_pkg;
    localparam int WORD_W  = 32;
    localparam int TAG_W   = 5;
    localparam int SAMP_W  = 24;
    localparam int TAG_LSB = 24;

    typedef enum logic [1:0] {
        SW_16 = 2'd0,
        SW_18 = 2'd1,
        SW_20 = 2'd2,
        SW_24 = 2'd3
    } samp_width_e;

    // Number of live sample bits for a width code.
    function automatic int width_bits(samp_width_e w);
        case (w)
            SW_16:   return 16;
            SW_18:   return 18;
            SW_20:   return 20;
            default: return 24;
        endcase
    endfunction
endpackage

// File: rtl/tsf_packer.sv
// Module: tsf_packer
// Builds the stored word from a tag and a sample. Bits above the chosen
// sample width are forced to zero, and the reserved top bits are zero.
// Assumes: width code is valid whenever a write is offered.
module tsf_packer
    import tsf_pkg::*;
(
    input  logic [TAG_W-1:0]  tag,
    input  logic [SAMP_W-1:0] sample,
    input  samp_width_e       wsel,
    output logic [WORD_W-1:0] word
);
    logic [SAMP_W-1:0] mask;
    logic [SAMP_W-1:0] field;

    // Mask of live sample bits for the selected width.
    always_comb begin
        mask = '0;
        for (int b = 0; b < SAMP_W; b++) begin
            if (b < width_bits(wsel)) mask[b] = 1'b1;
        end
    end

    // Assemble reserved bits, tag and masked sample.
    always_comb begin
        field = sample & mask;
        word  = {{(WORD_W-TAG_LSB-TAG_W){1'b0}}, tag, field};
    end

    // p_pad_zero_r2: no sample bit above the width reaches the word.
    always_comb begin
        if (wsel == SW_16) assert (word[23:16] == 8'h00) else $error("p_pad_zero_r2");
    end
endmodule

// File: rtl/tsf_store.sv
// Module: tsf_store
// Circular word store with read and write pointers and an occupancy
// counter. The read port is registered: a pop updates rd_data on the
// edge that accepts it; a refused read loads zero.
// Assumes: wr_acc is never raised while full, rd_acc never while empty.
module tsf_store #(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_acc,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              rd_acc,
    output logic [WORD_W-1:0] rd_data,
    output logic [CNT_W-1:0]  count
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wptr, rptr;

    // Wrap a pointer at the last slot.
    function automatic logic [PTR_W-1:0] nxt(logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    // Storage array write port.
    always_ff @(posedge clk) begin
        if (wr_acc) mem[wptr] <= wr_word;
    end

    // Pointer and occupancy maintenance.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (wr_acc) wptr <= nxt(wptr);
            if (rd_acc) rptr <= nxt(rptr);
            case ({wr_acc, rd_acc})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Registered read data; zero when no word is popped.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (rd_acc) rd_data <= mem[rptr];
        else             rd_data <= '0;
    end

    // p_level_bound_r3: occupancy never exceeds the depth.
    p_level_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    // p_flush_empties_r8: a flush leaves the store empty.
    p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> count == '0);
    // p_balanced_r11: push and pop together keep the count.
    p_balanced_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && rd_acc && !flush) |=> $stable(count));
endmodule

// File: rtl/tsf_flags.sv
// Module: tsf_flags
// Sticky overflow and underflow flags plus the threshold comparison.
// A set event outranks a host clear in the same cycle.
// Assumes: event inputs are single-cycle qualified strobes.
module tsf_flags #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ovf_evt,
    input  logic             unf_evt,
    input  logic             flag_wr,
    input  logic [1:0]       flag_wdata,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] thresh,
    input  logic             aux_sel,
    output logic             ovf_flag,
    output logic             unf_flag,
    output logic             thresh_flag,
    output logic             aux_out
);
    logic ovf_clr, unf_clr;

    // Decode host writes of zero into clear strobes.
    always_comb begin
        ovf_clr = flag_wr && !flag_wdata[0];
        unf_clr = flag_wr && !flag_wdata[1];
    end

    // Sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf_flag <= 1'b0;
        else if (ovf_evt) ovf_flag <= 1'b1;
        else if (ovf_clr) ovf_flag <= 1'b0;
    end

    // Sticky underflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n)       unf_flag <= 1'b0;
        else if (unf_evt) unf_flag <= 1'b1;
        else if (unf_clr) unf_flag <= 1'b0;
    end

    // Fill comparison and auxiliary routing.
    always_comb begin
        thresh_flag = count > thresh;
        aux_out     = aux_sel && thresh_flag;
    end

    // p_ovf_sticky_r6: overflow holds unless cleared by the host.
    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);
    // p_unf_sticky_r6: underflow holds unless cleared by the host.
    p_unf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (unf_flag && !unf_clr) |=> unf_flag);
    // p_ovf_set_r4: an overflow event always shows next cycle.
    p_ovf_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> ovf_flag);
endmodule

// File: rtl/tagged_sample_fifo.sv
// Module: tagged_sample_fifo (top)
// Channel-tagged sample buffer: packs tag and sample, stores words in
// order, and reports level, threshold and sticky error flags.
// Assumes: clr is a single-cycle pulse; inputs change away from the edge.
module tagged_sample_fifo
    import tsf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_valid,
    input  logic [4:0]         wr_tag,
    input  logic [23:0]        wr_sample,
    input  logic [1:0]         width_sel,
    input  logic               wr_enable,
    input  logic               clr,
    input  logic               rd_req,
    output logic [31:0]        rd_data,
    output logic [CNT_W-1:0]   level,
    output logic               full,
    output logic               empty,
    input  logic [CNT_W-1:0]   thresh,
    output logic               thresh_flag,
    input  logic               aux_sel,
    output logic               aux_out,
    input  logic               flag_wr,
    input  logic [1:0]         flag_wdata,
    output logic               ovf_flag,
    output logic               underflow_flag
);
    logic [WORD_W-1:0] packed_word;
    logic wr_try, rd_try, wr_acc, rd_acc, ovf_evt, unf_evt;

    // Pack the offered sample.
    tsf_packer u_pack (
        .tag    (wr_tag),
        .sample (wr_sample),
        .wsel   (samp_width_e'(width_sel)),
        .word   (packed_word)
    );

    // Qualify requests against clear, enable, full and empty.
    always_comb begin
        full    = level == CNT_W'(DEPTH);
        empty   = level == '0;
        wr_try  = wr_valid && wr_enable && !clr;
        rd_try  = rd_req && !clr;
        wr_acc  = wr_try && !full;
        rd_acc  = rd_try && !empty;
        ovf_evt = wr_try && full;
        unf_evt = rd_try && empty;
    end

    // Word storage.
    tsf_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (clr),
        .wr_acc  (wr_acc),
        .wr_word (packed_word),
        .rd_acc  (rd_acc),
        .rd_data (rd_data),
        .count   (level)
    );

    // Status flags.
    tsf_flags #(.CNT_W(CNT_W)) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .ovf_evt     (ovf_evt),
        .unf_evt     (unf_evt),
        .flag_wr     (flag_wr),
        .flag_wdata  (flag_wdata),
        .count       (level),
        .thresh      (thresh),
        .aux_sel     (aux_sel),
        .ovf_flag    (ovf_flag),
        .unf_flag    (underflow_flag),
        .thresh_flag (thresh_flag),
        .aux_out     (aux_out)
    );

    // p_full_drop_r4: a write on full without a read keeps the level.
    p_full_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_valid && !rd_req && !clr) |=> full);
    // p_empty_zero_r5: a read on empty returns zero.
    p_empty_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_req) |=> rd_data == '0);
    // p_disabled_hold_r9: a disabled write alone never raises the level.
    p_disabled_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_enable && !rd_req && !clr) |=> $stable(level));
    // p_reserved_zero_r1: popped words keep reserved bits clear.
    p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[31:29] == 3'b000);
endmodule

// File: tb/tagged_sample_fifo_tb.sv
module tagged_sample_fifo_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic clk = 0, rst_n = 0;
    logic wr_valid = 0, wr_enable = 1, clr = 0, rd_req = 0, aux_sel = 0, flag_wr = 0;
    logic [4:0] wr_tag = 0;
    logic [23:0] wr_sample = 0;
    logic [1:0] width_sel = 3, flag_wdata = 2'b11;
    logic [CNT_W-1:0] thresh = 4;
    logic [31:0] rd_data;
    logic [CNT_W-1:0] level;
    logic full, empty, thresh_flag, aux_out, ovf_flag, underflow_flag;
    int n_chk = 0, n_bad = 0;
    logic [31:0] got;

    // {tag, sample, width, expected word}
    localparam logic [62:0] VEC [8] = '{
        {5'h1F, 24'hFFFFFF, 2'd0, 32'h1F00FFFF},
        {5'h1F, 24'hFFFFFF, 2'd1, 32'h1F03FFFF},
        {5'h1F, 24'hFFFFFF, 2'd2, 32'h1F0FFFFF},
        {5'h1F, 24'hFFFFFF, 2'd3, 32'h1FFFFFFF},
        {5'h0A, 24'hABCDEF, 2'd0, 32'h0A00CDEF},
        {5'h0A, 24'hABCDEF, 2'd1, 32'h0A03CDEF},
        {5'h0A, 24'hABCDEF, 2'd2, 32'h0A0BCDEF},
        {5'h0A, 24'hABCDEF, 2'd3, 32'h0AABCDEF}
    };

    tagged_sample_fifo #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_tag(wr_tag),
        .wr_sample(wr_sample), .width_sel(width_sel), .wr_enable(wr_enable),
        .clr(clr), .rd_req(rd_req), .rd_data(rd_data), .level(level),
        .full(full), .empty(empty), .thresh(thresh), .thresh_flag(thresh_flag),
        .aux_sel(aux_sel), .aux_out(aux_out), .flag_wr(flag_wr),
        .flag_wdata(flag_wdata), .ovf_flag(ovf_flag),
        .underflow_flag(underflow_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Each task drives on a falling edge and returns on the next one.
    task automatic step();
        @(posedge clk); @(negedge clk);
        wr_valid = 0; rd_req = 0; clr = 0; flag_wr = 0;
    endtask

    task automatic push(input logic [4:0] t, input logic [23:0] s);
        wr_valid = 1; wr_tag = t; wr_sample = s; step();
    endtask

    task automatic pop(output logic [31:0] d);
        rd_req = 1; step(); d = rd_data;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk); rst_n = 1; @(negedge clk);
        // R10 reset state
        check(level == 0 && empty, "R10", 32'(level), 0);
        check(rd_data == 0, "R10", rd_data, 0);
        check(!ovf_flag && !underflow_flag, "R10", {ovf_flag, underflow_flag}, 0);

        // R1 R2 packing table
        for (int i = 0; i < 8; i++) begin
            width_sel = VEC[i][33:32];
            push(VEC[i][62:58], VEC[i][57:34]);
            pop(got);
            check(got == VEC[i][31:0], "R1/R2 pack", got, VEC[i][31:0]);
        end
        width_sel = 3;

        // R3 R7 fill, threshold, aux routing
        aux_sel = 1;
        for (int i = 0; i < DEPTH; i++) begin
            push(5'(i), 24'(i + 24'h100));
            check(level == CNT_W'(i + 1), "R3 level", 32'(level), 32'(i + 1));
            check(thresh_flag == (i + 1 > 4), "R7 thresh", 32'(thresh_flag), 32'(i + 1 > 4));
            check(aux_out == thresh_flag, "R7 aux", 32'(aux_out), 32'(thresh_flag));
        end
        aux_sel = 0; @(negedge clk);
        check(!aux_out, "R7 aux off", 32'(aux_out), 0);

        // R4 write on full
        check(full && !ovf_flag, "R4 pre", {full, ovf_flag}, 2'b10);
        push(5'h1E, 24'h777777);
        check(level == CNT_W'(DEPTH), "R4 level", 32'(level), DEPTH);
        check(ovf_flag, "R4 ovf", 32'(ovf_flag), 1);

        // R3 order and unchanged contents
        for (int i = 0; i < DEPTH; i++) begin
            pop(got);
            check(got == {3'b0, 5'(i), 24'(i + 24'h100)}, "R3 order", got, {3'b0, 5'(i), 24'(i + 24'h100)});
        end
        check(empty, "R3 empty", 32'(level), 0);

        // R5 read on empty
        pop(got);
        check(got == 0, "R5 data", got, 0);
        check(underflow_flag, "R5 flag", 32'(underflow_flag), 1);

        // R6 stickiness and host clearing
        step(); step();
        check(ovf_flag && underflow_flag, "R6 hold", {ovf_flag, underflow_flag}, 2'b11);
        flag_wr = 1; flag_wdata = 2'b11; step();
        check(ovf_flag && underflow_flag, "R6 write1", {ovf_flag, underflow_flag}, 2'b11);
        flag_wr = 1; flag_wdata = 2'b10; step();
        check(!ovf_flag && underflow_flag, "R6 clr ovf", {ovf_flag, underflow_flag}, 2'b01);
        flag_wr = 1; flag_wdata = 2'b00; rd_req = 1; step();
        check(underflow_flag, "R6 event wins", 32'(underflow_flag), 1);
        flag_wr = 1; flag_wdata = 2'b00; step();
        check(!underflow_flag, "R6 clr unf", 32'(underflow_flag), 0);

        // R9 disable
        push(5'h03, 24'h000033);
        wr_enable = 0;
        push(5'h04, 24'h000044);
        check(level == 1, "R9 ignored", 32'(level), 1);
        pop(got);
        check(got == 32'h03000033, "R9 read", got, 32'h03000033);
        for (int i = 0; i < DEPTH + 1; i++) push(5'h05, 24'h5);
        check(level == 0 && !ovf_flag, "R9 no ovf", {level, ovf_flag}, 0);
        wr_enable = 1;

        // R11 simultaneous read and write
        push(5'h06, 24'h000066);
        wr_valid = 1; wr_tag = 5'h07; wr_sample = 24'h77; rd_req = 1; step();
        check(level == 1, "R11 level", 32'(level), 1);
        check(rd_data == 32'h06000066, "R11 data", rd_data, 32'h06000066);
        pop(got);
        check(got == 32'h07000077, "R11 second", got, 32'h07000077);

        // R8 clear with concurrent write, flags untouched
        pop(got);
        check(underflow_flag, "R8 pre", 32'(underflow_flag), 1);
        push(5'h01, 24'h1); push(5'h02, 24'h2); push(5'h03, 24'h3);
        clr = 1; wr_valid = 1; rd_req = 1; step();
        check(level == 0 && empty, "R8 level", 32'(level), 0);
        check(underflow_flag && !ovf_flag, "R8 flags", {ovf_flag, underflow_flag}, 2'b01);
        push(5'h09, 24'h99);
        pop(got);
        check(got == 32'h09000099, "R8 after", got, 32'h09000099);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule